// File: doc/BRIEF.md
# Software Trap Entry and Return Controller

This block keeps the three live processor status flags: supervisor mode, interrupt enable and carry. It also keeps a backup copy of each flag and a backup program-counter register. It is the hardware half of a software trap. On a trap request it records where to resume, saves the flags, and turns off interrupts and carry. It then points the fetch unit at one of sixteen handler vectors. On the matching return-from-exception request it restores the flags and sends fetch back to the saved address, aligned to a word.

The saved address is the trap instruction address plus four. The saved value therefore keeps the halfword position of the trap: bit 1 is set when the trap sat on the second halfword of a word. On return, the two low bits are dropped, so traps at either halfword of a word resume at the same word-aligned address. The decoder supplies single-cycle requests. An ordinary status write port lets normal instructions set the live flags.

All outputs are registered. A request sampled at a rising clock edge becomes visible just after that edge.

Top module: `trap_ctl`

## Requirements
- R1: A trap with number n (0 to 15, `trapNum`) drives `nextPc` = `VEC_BASE` + 4*n. The sixteen numbers give sixteen distinct, consecutive word-spaced vector entries.
- R2: On a trap, the backup flags `bkSup`, `bkIntEn` and `bkCarry` take the values that `supMode`, `intEn` and `carry` held before the trap.
- R3: On a trap, `supMode` keeps its value, and `intEn` and `carry` become 0.
- R4: On a trap, `bkPc` becomes `instrAddr` + 4, modulo 2^32. For example, 0x04 gives 0x08, 0x06 gives 0x0A, and 0xFFFFFFFE gives 0x00000002.
- R5: Bit 1 of `bkPc` after a trap is 0 when `instrAddr` was word-aligned and 1 when it was on the second halfword.
- R6: On a return, `nextPc` = `bkPc` with bits 1:0 forced to 00. Both 0x08 and 0x0A give 0x08.
- R7: On a return, `supMode`, `intEn` and `carry` take the backup flag values, and the backup flags and `bkPc` do not change.
- R8: `nextPcValid` is 1 for exactly the one cycle after each accepted trap or return request, and 0 otherwise.
- R9: When a trap request and a return request arrive in the same cycle, only the trap takes effect.
- R10: With no trap, return or status write request, all flags, backup flags and `bkPc` hold their values.
- R11: A status write with no trap or return loads `statusWrData` into the live flags: bit 2 is supervisor mode, bit 1 is interrupt enable, bit 0 is carry. A trap or return in the same cycle takes priority over the write.
- R12: Reset (`rstN` low) clears every flag, every backup flag, `bkPc` and `nextPcValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| trapReq | input | 1 | Trap request, one cycle |
| trapNum | input | 4 | Trap number |
| instrAddr | input | 32 | Address of the trap instruction |
| retReq | input | 1 | Return-from-exception request, one cycle |
| statusWr | input | 1 | Live flag write strobe |
| statusWrData | input | 3 | {supervisor, interrupt enable, carry} write value |
| supMode | output | 1 | Live supervisor mode flag |
| intEn | output | 1 | Live interrupt enable flag |
| carry | output | 1 | Live carry flag |
| bkSup | output | 1 | Backup supervisor mode flag |
| bkIntEn | output | 1 | Backup interrupt enable flag |
| bkCarry | output | 1 | Backup carry flag |
| bkPc | output | 32 | Backup program counter |
| nextPc | output | 32 | Vector or return address |
| nextPcValid | output | 1 | `nextPc` is valid this cycle |

## Verification
The bench drives traps from both halfwords of a word and checks that the saved address differs in bit 1 while the return address is the same. Traps over all sixteen numbers separate a wrong vector scale or offset from a correct one. The flags are preset to ones and to mixed patterns before a trap, so that a missing backup copy or a wrong clear shows up. Collisions of a trap with a return and of a trap with a status write expose the priority order, and idle cycles and an address-wrap trap check holding and modulo arithmetic.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;
  // Strobes from the control decoder to the datapath; at most one is set.
  typedef struct packed {
    logic doTrap;
    logic doRet;
    logic doWr;
  } ctlStrobes_t;
endpackage

// File: rtl/trap_ctl_ctrl.sv
module trap_ctl_ctrl
  import trap_ctl_pkg::*;
(
  input  logic        trapReq,
  input  logic        retReq,
  input  logic        statusWr,
  output ctlStrobes_t strobes
);
  // Fixed priority: trap, then return, then plain status write.
  always_comb begin
    strobes = '0;
    if (trapReq)       strobes.doTrap = 1'b1;
    else if (retReq)   strobes.doRet  = 1'b1;
    else if (statusWr) strobes.doWr   = 1'b1;
  end
endmodule

// File: rtl/trap_ctl_dp.sv
module trap_ctl_dp
  import trap_ctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_W = 4,
  parameter logic [ADDR_W-1:0] VEC_BASE = 32'h0000_0040
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [NUM_W-1:0]  trapNum,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [2:0]        statusWrData,
  output logic [2:0]        liveFlags,
  output logic [2:0]        backFlags,
  output logic [ADDR_W-1:0] bkPc,
  output logic [ADDR_W-1:0] nextPc,
  output logic              nextPcValid
);
  localparam int PAD_W = ADDR_W - NUM_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] vecOffset;
  logic [ADDR_W-1:0] retAddr;

  assign vecOffset = {{PAD_W{1'b0}}, trapNum, 2'b00};
  assign retAddr   = {bkPc[ADDR_W-1:2], 2'b00};

  // Flag order inside the 3-bit vectors: [2] supervisor, [1] int enable, [0] carry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveFlags   <= '0;
      backFlags   <= '0;
      bkPc        <= '0;
      nextPc      <= '0;
      nextPcValid <= 1'b0;
    end else begin
      nextPcValid <= 1'b0;
      if (strobes.doTrap) begin
        backFlags   <= liveFlags;
        liveFlags   <= {liveFlags[2], 2'b00};
        bkPc        <= instrAddr + STEP;
        nextPc      <= VEC_BASE + vecOffset;
        nextPcValid <= 1'b1;
      end else if (strobes.doRet) begin
        liveFlags   <= backFlags;
        nextPc      <= retAddr;
        nextPcValid <= 1'b1;
      end else if (strobes.doWr) begin
        liveFlags   <= statusWrData;
      end
    end
  end
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
  import trap_ctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_W = 4,
  parameter logic [ADDR_W-1:0] VEC_BASE = 32'h0000_0040
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapReq,
  input  logic [NUM_W-1:0]  trapNum,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic              retReq,
  input  logic              statusWr,
  input  logic [2:0]        statusWrData,
  output logic              supMode,
  output logic              intEn,
  output logic              carry,
  output logic              bkSup,
  output logic              bkIntEn,
  output logic              bkCarry,
  output logic [ADDR_W-1:0] bkPc,
  output logic [ADDR_W-1:0] nextPc,
  output logic              nextPcValid
);
  ctlStrobes_t strobes;
  logic [2:0]  liveFlags;
  logic [2:0]  backFlags;

  trap_ctl_ctrl ctrl_i (
    .trapReq (trapReq),
    .retReq  (retReq),
    .statusWr(statusWr),
    .strobes (strobes)
  );

  trap_ctl_dp #(.ADDR_W(ADDR_W), .NUM_W(NUM_W), .VEC_BASE(VEC_BASE)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .trapNum     (trapNum),
    .instrAddr   (instrAddr),
    .statusWrData(statusWrData),
    .liveFlags   (liveFlags),
    .backFlags   (backFlags),
    .bkPc        (bkPc),
    .nextPc      (nextPc),
    .nextPcValid (nextPcValid)
  );

  assign {supMode, intEn, carry}   = liveFlags;
  assign {bkSup, bkIntEn, bkCarry} = backFlags;
endmodule

// File: rtl/trap_ctl_chk.sv
module trap_ctl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              trapReq,
  input logic [ADDR_W-1:0] instrAddr,
  input logic              retReq,
  input logic              statusWr,
  input logic              supMode,
  input logic              intEn,
  input logic              carry,
  input logic              bkSup,
  input logic              bkIntEn,
  input logic              bkCarry,
  input logic [ADDR_W-1:0] bkPc,
  input logic [ADDR_W-1:0] nextPc,
  input logic              nextPcValid
);
  a_r2_backup_copy: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> (bkSup == $past(supMode)) && (bkIntEn == $past(intEn)) && (bkCarry == $past(carry)));

  a_r3_entry_flags: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> !intEn && !carry && (supMode == $past(supMode)));

  a_r4_saved_pc: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> bkPc == $past(instrAddr) + ADDR_W'(4));

  a_r6_return_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !trapReq) |=> nextPcValid && (nextPc[1:0] == 2'b00) && (nextPc[ADDR_W-1:2] == $past(bkPc[ADDR_W-1:2])));

  a_r7_backup_kept: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !trapReq) |=> $stable(bkPc) && $stable(bkSup) && $stable(bkIntEn) && $stable(bkCarry));

  a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!trapReq && !retReq) |=> !nextPcValid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!trapReq && !retReq && !statusWr) |=> $stable(bkPc) && $stable(supMode) && $stable(intEn) && $stable(carry));

  // R12: reset state seen while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_r12_reset: assert (!nextPcValid && !supMode && !intEn && !carry && (bkPc == '0));
    end
  end
endmodule

bind trap_ctl trap_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .instrAddr(instrAddr),
  .retReq(retReq), .statusWr(statusWr), .supMode(supMode), .intEn(intEn),
  .carry(carry), .bkSup(bkSup), .bkIntEn(bkIntEn), .bkCarry(bkCarry),
  .bkPc(bkPc), .nextPc(nextPc), .nextPcValid(nextPcValid)
);

// File: tb/trap_ctl_tb_top.sv
module trap_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VBASE = 32'h0000_0040;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapReq = 1'b0, retReq = 1'b0, statusWr = 1'b0;
  logic [3:0]  trapNum = '0;
  logic [31:0] instrAddr = '0;
  logic [2:0]  statusWrData = '0;
  logic supMode, intEn, carry, bkSup, bkIntEn, bkCarry, nextPcValid;
  logic [31:0] bkPc, nextPc;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_ctl #(.VEC_BASE(VBASE)) dut_i (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapNum(trapNum),
    .instrAddr(instrAddr), .retReq(retReq), .statusWr(statusWr),
    .statusWrData(statusWrData), .supMode(supMode), .intEn(intEn),
    .carry(carry), .bkSup(bkSup), .bkIntEn(bkIntEn), .bkCarry(bkCarry),
    .bkPc(bkPc), .nextPc(nextPc), .nextPcValid(nextPcValid)
  );

  typedef struct {
    logic [2:0]  live;
    logic [2:0]  back;
    logic [31:0] bpc;
    logic        valid;
    logic [31:0] npc;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // Reference model state
  logic [2:0]  mLive = '0;
  logic [2:0]  mBack = '0;
  logic [31:0] mBpc = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, push expected result after the edge.
  task automatic drive(input bit t, input logic [3:0] n, input logic [31:0] a,
                       input bit r, input bit w, input logic [2:0] wd, input string tag);
    expItem_t e;
    @(negedge clk);
    trapReq = t; trapNum = n; instrAddr = a; retReq = r; statusWr = w; statusWrData = wd;
    e.valid = 1'b0;
    e.npc = '0;
    if (t) begin
      mBack = mLive;
      mLive = {mLive[2], 2'b00};
      mBpc = a + 32'd4;
      e.valid = 1'b1;
      e.npc = VBASE + 32'(n) * 32'd4;
    end else if (r) begin
      mLive = mBack;
      e.valid = 1'b1;
      e.npc = mBpc & 32'hFFFF_FFFC;
    end else if (w) begin
      mLive = wd;
    end
    e.live = mLive; e.back = mBack; e.bpc = mBpc; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 4'd0, 32'd0, 1'b0, 1'b0, 3'b000, tag);
  endtask

  // Monitor: compare just after each edge that follows a driven cycle.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check({supMode, intEn, carry} == e.live, {e.tag, " live flags"}, 32'({supMode, intEn, carry}), 32'(e.live));
      check({bkSup, bkIntEn, bkCarry} == e.back, {e.tag, " backup flags"}, 32'({bkSup, bkIntEn, bkCarry}), 32'(e.back));
      check(bkPc == e.bpc, {e.tag, " bkPc"}, bkPc, e.bpc);
      check(nextPcValid == e.valid, {e.tag, " R8 valid"}, 32'(nextPcValid), 32'(e.valid));
      if (e.valid) check(nextPc == e.npc, {e.tag, " nextPc"}, nextPc, e.npc);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check({supMode, intEn, carry, bkSup, bkIntEn, bkCarry} == 6'b0, "R12 flags", 32'({supMode, intEn, carry, bkSup, bkIntEn, bkCarry}), 32'd0);
    check(bkPc == 32'd0, "R12 bkPc", bkPc, 32'd0);
    check(nextPcValid == 1'b0, "R12 valid", 32'(nextPcValid), 32'd0);
    rstN = 1'b1;

    drive(1'b0, 4'd0, 32'd0, 1'b0, 1'b1, 3'b111, "R11 write all ones");
    drive(1'b1, 4'd0, 32'h04, 1'b0, 1'b0, 3'b000, "R2 R3 R4 R5 trap aligned");
    idle("R10 idle after trap");
    drive(1'b0, 4'd0, 32'd0, 1'b1, 1'b0, 3'b000, "R6 R7 return from 0x08");
    drive(1'b0, 4'd0, 32'd0, 1'b0, 1'b1, 3'b101, "R11 write 101");
    drive(1'b1, 4'd15, 32'h06, 1'b0, 1'b0, 3'b000, "R1 R4 R5 trap halfword");
    drive(1'b0, 4'd0, 32'd0, 1'b1, 1'b0, 3'b000, "R6 return from 0x0A");
    drive(1'b0, 4'd0, 32'd0, 1'b1, 1'b0, 3'b000, "R7 second return");
    for (int i = 0; i < 16; i++) begin
      drive(1'b0, 4'd0, 32'd0, 1'b0, 1'b1, 3'(i), "R11 preset");
      drive(1'b1, 4'(i), 32'h100 + 32'(i) * 32'd2, 1'b0, 1'b0, 3'b000, "R1 R2 R3 vector sweep");
    end
    drive(1'b0, 4'd0, 32'd0, 1'b0, 1'b1, 3'b011, "R11 write 011");
    drive(1'b1, 4'd7, 32'h200, 1'b1, 1'b0, 3'b000, "R9 trap beats return");
    drive(1'b1, 4'd3, 32'h30A, 1'b0, 1'b1, 3'b111, "R11 trap beats write");
    idle("R8 R10 idle");
    idle("R10 idle");
    drive(1'b1, 4'd2, 32'hFFFF_FFFE, 1'b0, 1'b0, 3'b000, "R4 wrap");
    drive(1'b0, 4'd0, 32'd0, 1'b1, 1'b0, 3'b000, "R6 return after wrap");
    idle("R8 idle after return");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule